// File: doc/BRIEF.md
# Disciplined Pulse-Per-Second Generator with Resynchronization

This block turns a free-running local oscillator clock into a once-per-second timing pulse by counting clock cycles. Each pulse has a fixed width. The same clock, divided by two, drives the timebase of an external time-interval measurement chip. Two indicator outputs stretch the local pulse and an external reference pulse to a 10% duty cycle, so that front-panel LEDs can show them. Phase measurement and oscillator steering belong to other blocks.

Bringing a disciplined oscillator into phase lock takes a long time if the local second boundary starts far from the reference. To shorten it, a synchronize command arms a one-shot realignment. At the next rising edge of the reference pulse, the second counter reloads so that a local pulse starts on that edge. The reference pulse and the command are asynchronous, so both pass through a flop synchronizer first. An output enable holds the pulse output low without stopping the counter, so the phase is kept while the output is off.

With the default parameters the block runs from a 10 MHz clock. The pulse is 200 cycles (20 µs) wide, and each LED stays on for 1,000,000 cycles (100 ms).

Top module: `pps_discipline_gen`

## Requirements
- R1: While reset is high, and in the sampled cycles while it is held, pps_o, tdc_clk_o, led_local_o and led_ref_o are all low. The first pulse starts in the first clock cycle after reset is released.
- R2: With no realignment, pps_o rises once every PERIOD_CYC clock cycles.
- R3: Each pulse on pps_o stays high for exactly PULSE_CYC consecutive cycles.
- R4: tdc_clk_o toggles on every clock edge, which gives half the input clock frequency. It is low during reset.
- R5: led_local_o goes high with each local second boundary and stays high for PERIOD_CYC/LED_DIV cycles. This output is not affected by out_en_i.
- R6: Each rising edge detected on ref_pps_i turns led_ref_o on for PERIOD_CYC/LED_DIV cycles. A new edge restarts the full interval. If no further edge arrives, led_ref_o goes low when the interval ends.
- R7: A high level on sync_req_i arms a realignment. At the next detected rising edge of ref_pps_i, a local pulse begins. With SYNC_STAGES=2, pps_o is high in the cycle after the third clock edge that follows the rise of ref_pps_i, and timing then continues from that new boundary.
- R8: A rising edge of ref_pps_i that arrives while no realignment is armed leaves the pps_o phase unchanged.
- R9: One armed request performs exactly one realignment. A later reference edge with no new command does not move the phase.
- R10: While out_en_i is low, pps_o is low. The second counter keeps running, so pulses resume at the unchanged phase once out_en_i goes high again.
- R11: ref_pps_i and sync_req_i each pass through SYNC_STAGES flops before they are used. The reference edge is detected one cycle after the synchronizer output rises, so with two stages it takes effect at the third clock edge, and no earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pps_i | input | 1 | External reference pulse, asynchronous |
| sync_req_i | input | 1 | Realignment command, asynchronous, level-sensitive |
| out_en_i | input | 1 | Pulse output enable; when low it forces pps_o low |
| pps_o | output | 1 | Local once-per-second pulse |
| tdc_clk_o | output | 1 | Clock divided by two for the interval measurement chip |
| led_local_o | output | 1 | 10% duty indicator of the local pulse |
| led_ref_o | output | 1 | Stretched indicator of the reference pulse |

## Verification
A wrong count in the second counter shows up as a shifted or missing rise on pps_o and led_local_o. It appears no later than one full period after the fault, and for a wrong pulse width within PULSE_CYC cycles. A stuck or wrongly cleared armed state shows up at the next reference edge: the pulse phase either jumps when it should stay or stays when it should jump, and the error is visible three cycles after that edge. A faulty stretch counter shows on led_ref_o by the end of the LED interval, and the bench compares every output in every cycle against an arithmetic model of the requirements.

// File: rtl/pps_pkg.sv
package pps_pkg;

   // State of a pending realignment request
   typedef enum logic {
      ARM_IDLE = 1'b0,
      ARM_WAIT = 1'b1
   } arm_t;

   // Width of a counter holding values 0..n-1 (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pps_sync_chain.sv
module pps_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pps_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg_q[0] <= 1'b0;
            else     stg_q[0] <= d_i;
         end
         // R11: first stage samples the raw input
         p_first_stage_r11 : assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> stg_q[0] == $past(d_i));
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg_q[i] <= 1'b0;
            else     stg_q[i] <= stg_q[i-1];
         end
         // R11: each later stage delays the previous one by one cycle
         p_shift_stage_r11 : assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> stg_q[i] == $past(stg_q[i-1]));
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pps_second_counter.sv
module pps_second_counter #(
   parameter int unsigned PERIOD_CYC = 10_000_000,
   parameter int unsigned PULSE_CYC  = 200,
   parameter int unsigned LED_CYC    = 1_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic realign_i,
   output logic pulse_o,
   output logic led_o
);
   import pps_pkg::*;

   localparam int unsigned   CW     = cnt_width(PERIOD_CYC);
   localparam logic [CW-1:0] LAST   = CW'(PERIOD_CYC - 1);
   localparam logic [CW-1:0] PW_LIM = CW'(PULSE_CYC);
   localparam logic [CW-1:0] LW_LIM = CW'(LED_CYC);

   if (PERIOD_CYC < 4) begin : g_bad_period
      $error("pps_second_counter: PERIOD_CYC too small");
   end
   if (PULSE_CYC == 0 || PULSE_CYC >= PERIOD_CYC) begin : g_bad_pulse
      $error("pps_second_counter: PULSE_CYC out of range");
   end
   if (LED_CYC == 0 || LED_CYC >= PERIOD_CYC) begin : g_bad_led
      $error("pps_second_counter: LED_CYC out of range");
   end

   logic [CW-1:0] cnt_q;

   // Reset parks the count on the last cycle, so the first pulse
   // starts one cycle after reset is released
   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= LAST;
      else if (realign_i)     cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + CW'(1);
   end

   assign pulse_o = (cnt_q < PW_LIM);
   assign led_o   = (cnt_q < LW_LIM);

   // R2: the count wraps from the last cycle to the start
   p_wrap_r2 : assert property (@(posedge clk) disable iff (rst)
      (cnt_q == LAST && !realign_i) |=> cnt_q == '0);
   // R2: away from the wrap, and with no realignment, the count advances by one
   p_step_r2 : assert property (@(posedge clk) disable iff (rst)
      (cnt_q != LAST && !realign_i) |=> cnt_q == $past(cnt_q) + CW'(1));
   // R7: a realignment starts a new second
   p_reload_r7 : assert property (@(posedge clk) disable iff (rst)
      realign_i |=> pulse_o && led_o);
   // R3: the pulse falls only after its last cycle
   p_pulse_end_r3 : assert property (@(posedge clk) disable iff (rst)
      (pulse_o && !realign_i && cnt_q != PW_LIM - CW'(1)) |=> pulse_o);

endmodule

// File: rtl/pps_stretcher.sv
module pps_stretcher #(
   parameter int unsigned LEN = 1_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_i,
   output logic led_o
);
   import pps_pkg::*;

   localparam int unsigned   SW      = cnt_width(LEN + 1);
   localparam logic [SW-1:0] LEN_VAL = SW'(LEN);

   if (LEN == 0) begin : g_bad_len
      $error("pps_stretcher: LEN must be nonzero");
   end

   logic [SW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst)               left_q <= '0;
      else if (trig_i)       left_q <= LEN_VAL;
      else if (left_q != '0) left_q <= left_q - SW'(1);
   end

   assign led_o = (left_q != '0);

   // R6: every trigger restarts the full interval
   p_load_r6 : assert property (@(posedge clk) disable iff (rst)
      trig_i |=> left_q == LEN_VAL);
   // R6: the indicator goes dark after the final count when no new trigger arrives
   p_expire_r6 : assert property (@(posedge clk) disable iff (rst)
      (left_q == SW'(1) && !trig_i) |=> !led_o);

endmodule

// File: rtl/pps_discipline_gen.sv
module pps_discipline_gen #(
   parameter int unsigned PERIOD_CYC  = 10_000_000,
   parameter int unsigned PULSE_CYC   = 200,
   parameter int unsigned LED_DIV     = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_pps_i,
   input  logic sync_req_i,
   input  logic out_en_i,
   output logic pps_o,
   output logic tdc_clk_o,
   output logic led_local_o,
   output logic led_ref_o
);
   import pps_pkg::*;

   localparam int unsigned LED_CYC = PERIOD_CYC / LED_DIV;

   if (LED_DIV < 2) begin : g_bad_div
      $error("pps_discipline_gen: LED_DIV must be at least 2");
   end

   logic ref_s, cmd_s, ref_prev_q, ref_edge;
   logic realign, pulse_raw, tdc_q;
   arm_t arm_q;

   pps_sync_chain #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk(clk), .rst(rst), .d_i(ref_pps_i), .q_o(ref_s)
   );

   pps_sync_chain #(.STAGES(SYNC_STAGES)) u_cmd_sync (
      .clk(clk), .rst(rst), .d_i(sync_req_i), .q_o(cmd_s)
   );

   always_ff @(posedge clk) begin
      if (rst) ref_prev_q <= 1'b0;
      else     ref_prev_q <= ref_s;
   end

   assign ref_edge = ref_s & ~ref_prev_q;
   assign realign  = ref_edge & (arm_q == ARM_WAIT);

   // One-shot request: consumed by the edge it acts on
   always_ff @(posedge clk) begin
      if (rst)          arm_q <= ARM_IDLE;
      else if (realign) arm_q <= ARM_IDLE;
      else if (cmd_s)   arm_q <= ARM_WAIT;
   end

   pps_second_counter #(
      .PERIOD_CYC(PERIOD_CYC),
      .PULSE_CYC (PULSE_CYC),
      .LED_CYC   (LED_CYC)
   ) u_second (
      .clk(clk), .rst(rst), .realign_i(realign),
      .pulse_o(pulse_raw), .led_o(led_local_o)
   );

   pps_stretcher #(.LEN(LED_CYC)) u_ref_led (
      .clk(clk), .rst(rst), .trig_i(ref_edge), .led_o(led_ref_o)
   );

   always_ff @(posedge clk) begin
      if (rst) tdc_q <= 1'b0;
      else     tdc_q <= ~tdc_q;
   end

   assign tdc_clk_o = tdc_q;
   assign pps_o     = out_en_i & pulse_raw;

   // R9: an armed request is cleared by the edge it acts on
   p_disarm_r9 : assert property (@(posedge clk) disable iff (rst)
      realign |=> arm_q == ARM_IDLE);
   // R7: a command with no concurrent realignment leaves the block armed
   p_arm_r7 : assert property (@(posedge clk) disable iff (rst)
      (cmd_s && !realign) |=> arm_q == ARM_WAIT);
   // R7: an armed edge starts a pulse in the next cycle when the output is enabled
   p_realign_r7 : assert property (@(posedge clk) disable iff (rst)
      realign |=> (pps_o == out_en_i));
   // R4: the divided clock changes on every edge
   p_tdc_toggle_r4 : assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> tdc_clk_o != $past(tdc_clk_o));
   // R5: the local indicator is on whenever a pulse begins
   p_led_follow_r5 : assert property (@(posedge clk) disable iff (rst)
      $rose(pps_o) |-> led_local_o);

endmodule

// File: tb/sim_pps_discipline_gen.sv
module sim_pps_discipline_gen;

   localparam int P  = 1000;
   localparam int W  = 20;
   localparam int LD = 10;
   localparam int L  = P / LD;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst = 1'b1, ref_pps = 1'b0, sync_req = 1'b0, out_en = 1'b1;
   logic pps, tdc_clk, led_loc, led_ref;

   pps_discipline_gen #(.PERIOD_CYC(P), .PULSE_CYC(W), .LED_DIV(LD), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst(rst), .ref_pps_i(ref_pps), .sync_req_i(sync_req),
      .out_en_i(out_en), .pps_o(pps), .tdc_clk_o(tdc_clk),
      .led_local_o(led_loc), .led_ref_o(led_ref)
   );

   int n_chk = 0, n_err = 0, cyc = 0;
   string ctx = "R2";
   bit done = 0;

   // Requirement-level model state
   int  m_cnt = P - 1, m_rled = 0;
   bit  m_arm = 0, m_tdc = 0;
   bit  r1 = 0, r2 = 0, r3 = 0, c1 = 0, c2 = 0;

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic step();
      bit e;
      @(posedge clk);
      e = r2 & ~r3;
      if (e && m_arm) m_cnt = 0;
      else            m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
      if (e && m_arm) m_arm = 0;
      else            m_arm = m_arm | c2;
      if (e)               m_rled = L;
      else if (m_rled > 0) m_rled = m_rled - 1;
      r3 = r2; r2 = r1; r1 = ref_pps;
      c2 = c1; c1 = sync_req;
      m_tdc = ~m_tdc;
      @(negedge clk);
      cyc++;
      chk({ctx, " pps_o (R3 width)"}, pps, out_en & (m_cnt < W));
      chk("R4 tdc_clk_o", tdc_clk, m_tdc);
      chk({ctx, " R5 led_local_o"}, led_loc, m_cnt < L);
      chk({ctx, " R6 led_ref_o"}, led_ref, m_rled != 0);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic ref_pulse(input int hi);
      ref_pps = 1'b1;
      run(hi);
      ref_pps = 1'b0;
   endtask

   task automatic wait_phase(input int ph);
      while (m_cnt != ph) step();
   endtask

   initial begin
      #(20 * 200000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!done) $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      // R1: outputs low while reset is held
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R1 pps_o in reset", pps, 1'b0);
         chk("R1 tdc_clk_o in reset", tdc_clk, 1'b0);
         chk("R1 led_local_o in reset", led_loc, 1'b0);
         chk("R1 led_ref_o in reset", led_ref, 1'b0);
      end
      rst = 1'b0;
      step();
      chk("R1 first pulse after reset", pps, 1'b1);

      // R2, R3, R4, R5: free running over several seconds
      ctx = "R2";
      run(2500);

      // R8: reference edge with no armed request
      ctx = "R8";
      wait_phase(500);
      ref_pulse(5);
      run(600);
      wait_phase(P - 1);
      step();
      chk("R8 phase kept after unarmed edge", pps, 1'b1);

      // R7, R11: arm, then realign on the next reference edge
      ctx = "R7";
      wait_phase(400);
      sync_req = 1'b1;
      run(4);
      sync_req = 1'b0;
      run(10);
      ref_pps = 1'b1;
      step();
      step();
      chk("R11 no realignment before third edge", pps, 1'b0);
      step();
      chk("R7 pulse starts three edges after reference", pps, 1'b1);
      run(2);
      ref_pps = 1'b0;
      run(1200);

      // R9: a later edge with no new command does not move the phase
      ctx = "R9";
      wait_phase(300);
      ref_pulse(5);
      run(100);
      chk("R9 phase unchanged after second edge", pps, 1'b0);
      run(900);

      // R6: retriggered stretch, then silence
      ctx = "R6";
      ref_pulse(3);
      run(40);
      ref_pulse(3);
      run(300);
      chk("R6 reference LED off after silence", led_ref, 1'b0);

      // R10: output disabled for over a second, phase retained
      ctx = "R10";
      out_en = 1'b0;
      run(1100);
      out_en = 1'b1;
      run(1100);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule